// File: doc/BRIEF.md
# Register Alias Rename Table

This block is the rename map for a small out-of-order core. Every architectural register has one entry. The entry either says the newest value already sits in the register file ("ready"), or it holds the tag of the functional-unit slot that will produce that value ("busy"). A tag is a unit class in the upper two bits and a slot number in the lower two bits. The class codes are: 0 load/store, 1 adder, 2 multiplier, 3 branch. The table only carries these as opaque patterns.

Each cycle, a rename group of up to four decoded instructions arrives. Lane 0 is the oldest and lane 3 the youngest. Each lane presents two source register numbers, an optional destination and the fresh tag chosen for that destination. The block answers each source in the same cycle. The answer is a busy flag plus a producer tag, or ready with a tag of zero. A source first sees writes by older lanes in the group, then completions broadcast in the same cycle, then the table. At the next clock edge, the table takes the group's destination mappings, clears entries whose producers have completed, and obeys a flush that sends every entry back to the register file.

Giving every destination a fresh tag removes write-after-read and write-after-write hazards between instructions in flight. A busy source is a true read-after-write dependence that must wait for its producer's broadcast.

Top module: `rename_alias_table`

## Requirements
- R1: After reset, every register looks up as ready (busy 0, tag 0). A ready answer always carries tag 0.
- R2: A source whose entry holds a producer tag looks up as busy with that tag.
- R3: A lane with valid and write enable both set, and a nonzero destination, makes the destination's entry busy with that lane's tag. The new mapping is visible from the next cycle.
- R4: A source in lane i whose register equals the destination of a writing lane j < i in the same group returns busy with lane j's tag. If several older lanes write that register, the youngest of them supplies the tag.
- R5: A lane's own destination does not affect its own sources. They return the mapping from older lanes or from the table.
- R6: When several lanes of one group write the same register, the youngest such lane's tag is left in the entry.
- R7: A completion broadcast clears an entry to ready only when the entry holds exactly the broadcast tag. A busy entry holding a different tag is unchanged.
- R8: If, in one cycle, a register's entry is cleared by a completion and that register is also renamed, the entry ends busy with the new tag. This holds even when the new tag equals the completed tag.
- R9: A source whose table entry matches a completion broadcast in the same cycle looks up as ready, unless an older lane of the group writes that register.
- R10: A flush makes every entry ready at the next edge. Renames presented in the flush cycle are dropped.
- R11: Register 0 is never renamed. As a source it always returns ready with tag 0, even when a lane names it as destination.
- R12: A lane with valid low, or with write enable low, neither updates the table nor supplies a tag to younger lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Return all entries to the register file at the next edge |
| ren_valid_i | input | LANES | Per-lane instruction valid |
| ren_dst_we_i | input | LANES | Per-lane destination write enable |
| ren_dst_i | input | LANES*AW | Per-lane destination register, lane i at bits [i*AW +: AW] |
| ren_tag_i | input | LANES*TAG_W | Per-lane new producer tag |
| ren_src_a_i | input | LANES*AW | Per-lane first source register |
| ren_src_b_i | input | LANES*AW | Per-lane second source register |
| cmp_valid_i | input | NUM_CMP | Completion broadcast valid per port |
| cmp_tag_i | input | NUM_CMP*TAG_W | Completed producer tag per port |
| src_a_busy_o | output | LANES | First source still waits on a producer |
| src_a_tag_o | output | LANES*TAG_W | Producer tag for the first source, zero when ready |
| src_b_busy_o | output | LANES | Second source still waits on a producer |
| src_b_tag_o | output | LANES*TAG_W | Producer tag for the second source, zero when ready |

## Verification
A corrupted entry is visible only when some later lane reads that register. It then returns the wrong busy flag or tag in that same cycle. A missed clear or missed set shows up one cycle after the broadcast or rename. A wrong bypass priority shows up in the same cycle as the group, as a stale tag in a younger lane. For this reason the stimulus follows every update with probe groups that read the touched registers. A long stretch of groups aimed at eight registers forces many collisions among lanes, broadcasts and flushes.

// File: rtl/rat_pkg.sv
package rat_pkg;

    localparam int unsigned RAT_NUM_REGS = 32;
    localparam int unsigned RAT_LANES    = 4;
    localparam int unsigned RAT_CLASS_W  = 2;
    localparam int unsigned RAT_SLOT_W   = 2;
    localparam int unsigned RAT_TAG_W    = RAT_CLASS_W + RAT_SLOT_W;
    localparam int unsigned RAT_NUM_CMP  = 2;

    typedef enum logic [RAT_CLASS_W-1:0] {
        UNIT_LDST = 2'd0,
        UNIT_ADD  = 2'd1,
        UNIT_MUL  = 2'd2,
        UNIT_BR   = 2'd3
    } unit_class_e;

    function automatic logic [RAT_TAG_W-1:0] make_tag(unit_class_e cls, logic [RAT_SLOT_W-1:0] slot);
        return {cls, slot};
    endfunction

endpackage

// File: rtl/rat_map_table.sv
module rat_map_table
    import rat_pkg::*;
#(
    parameter int unsigned NUM_REGS = RAT_NUM_REGS,
    parameter int unsigned LANES    = RAT_LANES,
    parameter int unsigned TAG_W    = RAT_TAG_W,
    parameter int unsigned NUM_CMP  = RAT_NUM_CMP,
    localparam int unsigned AW      = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush_i,
    input  logic [LANES-1:0]          wr_valid_i,
    input  logic [LANES*AW-1:0]       wr_dst_i,
    input  logic [LANES*TAG_W-1:0]    wr_tag_i,
    input  logic [NUM_CMP-1:0]        cmp_valid_i,
    input  logic [NUM_CMP*TAG_W-1:0]  cmp_tag_i,
    output logic [NUM_REGS-1:0]       busy_o,
    output logic [NUM_REGS*TAG_W-1:0] tag_o
);

    typedef struct packed {
        logic [NUM_REGS-1:0]       busy;
        logic [NUM_REGS*TAG_W-1:0] tag;
    } map_t;

    map_t                st_d, st_q;
    logic [NUM_REGS-1:0] wr_hit;
    logic [NUM_REGS-1:0] cmp_hit;

    // Next-state: completion clear first, then lane writes oldest to youngest
    // so the youngest writer is left standing; flush overrides everything.
    always_comb begin
        st_d    = st_q;
        wr_hit  = '0;
        cmp_hit = '0;
        for (int r = 1; r < NUM_REGS; r++) begin
            for (int k = 0; k < NUM_CMP; k++) begin
                if (st_q.busy[r] && cmp_valid_i[k] &&
                    cmp_tag_i[k*TAG_W +: TAG_W] == st_q.tag[r*TAG_W +: TAG_W]) begin
                    cmp_hit[r] = 1'b1;
                end
            end
            if (cmp_hit[r]) begin
                st_d.busy[r]                = 1'b0;
                st_d.tag[r*TAG_W +: TAG_W]  = '0;
            end
            for (int l = 0; l < LANES; l++) begin
                if (wr_valid_i[l] && wr_dst_i[l*AW +: AW] == AW'(r)) begin
                    wr_hit[r]                  = 1'b1;
                    st_d.busy[r]               = 1'b1;
                    st_d.tag[r*TAG_W +: TAG_W] = wr_tag_i[l*TAG_W +: TAG_W];
                end
            end
        end
        if (flush_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign tag_o  = st_q.tag;

    assert_flush_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.busy == '0));

    assert_reg0_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i[0] && wr_dst_i[0 +: AW] == '0 |=> !st_q.busy[0]);

    for (genvar r = 1; r < NUM_REGS; r++) begin : g_entry_chk
        assert_rename_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hit[r] && !flush_i |=> st_q.busy[r]);

        assert_cmp_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_hit[r] && !wr_hit[r] |=> !st_q.busy[r]);

        assert_stale_cmp_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.busy[r] && !cmp_hit[r] && !wr_hit[r] && !flush_i
            |=> st_q.busy[r] && $stable(st_q.tag[r*TAG_W +: TAG_W]));
    end

endmodule

// File: rtl/rat_src_lookup.sv
module rat_src_lookup
    import rat_pkg::*;
#(
    parameter int unsigned NUM_REGS = RAT_NUM_REGS,
    parameter int unsigned LANES    = RAT_LANES,
    parameter int unsigned TAG_W    = RAT_TAG_W,
    parameter int unsigned NUM_CMP  = RAT_NUM_CMP,
    parameter int unsigned LANE     = 0,
    localparam int unsigned AW      = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [AW-1:0]             src_i,
    input  logic [NUM_REGS-1:0]       map_busy_i,
    input  logic [NUM_REGS*TAG_W-1:0] map_tag_i,
    input  logic [LANES-1:0]          grp_wr_i,
    input  logic [LANES*AW-1:0]       grp_dst_i,
    input  logic [LANES*TAG_W-1:0]    grp_tag_i,
    input  logic [NUM_CMP-1:0]        cmp_valid_i,
    input  logic [NUM_CMP*TAG_W-1:0]  cmp_tag_i,
    output logic                      busy_o,
    output logic [TAG_W-1:0]          tag_o
);

    logic             res_busy;
    logic [TAG_W-1:0] res_tag;

    // Priority, lowest first: table, same-cycle completion, older lanes
    // (oldest to youngest, so the youngest older writer wins).
    always_comb begin
        res_busy = map_busy_i[src_i];
        res_tag  = map_tag_i[src_i*TAG_W +: TAG_W];
        for (int k = 0; k < NUM_CMP; k++) begin
            if (res_busy && cmp_valid_i[k] && cmp_tag_i[k*TAG_W +: TAG_W] == res_tag) begin
                res_busy = 1'b0;
            end
        end
        for (int j = 0; j < LANES; j++) begin
            if (j < LANE && grp_wr_i[j] && grp_dst_i[j*AW +: AW] == src_i) begin
                res_busy = 1'b1;
                res_tag  = grp_tag_i[j*TAG_W +: TAG_W];
            end
        end
        if (src_i == '0) begin
            res_busy = 1'b0;
        end
        if (!res_busy) begin
            res_tag = '0;
        end
    end

    assign busy_o = res_busy;
    assign tag_o  = res_tag;

    assert_zero_src_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        src_i == '0 |-> !busy_o);

    assert_ready_tag_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tag_o == '0);

    assert_table_busy_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        src_i != '0 && map_busy_i[src_i] && cmp_valid_i == '0 |-> busy_o);

endmodule

// File: rtl/rename_alias_table.sv
module rename_alias_table
    import rat_pkg::*;
#(
    parameter int unsigned NUM_REGS = RAT_NUM_REGS,
    parameter int unsigned LANES    = RAT_LANES,
    parameter int unsigned TAG_W    = RAT_TAG_W,
    parameter int unsigned NUM_CMP  = RAT_NUM_CMP,
    localparam int unsigned AW      = $clog2(NUM_REGS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush_i,
    input  logic [LANES-1:0]         ren_valid_i,
    input  logic [LANES-1:0]         ren_dst_we_i,
    input  logic [LANES*AW-1:0]      ren_dst_i,
    input  logic [LANES*TAG_W-1:0]   ren_tag_i,
    input  logic [LANES*AW-1:0]      ren_src_a_i,
    input  logic [LANES*AW-1:0]      ren_src_b_i,
    input  logic [NUM_CMP-1:0]       cmp_valid_i,
    input  logic [NUM_CMP*TAG_W-1:0] cmp_tag_i,
    output logic [LANES-1:0]         src_a_busy_o,
    output logic [LANES*TAG_W-1:0]   src_a_tag_o,
    output logic [LANES-1:0]         src_b_busy_o,
    output logic [LANES*TAG_W-1:0]   src_b_tag_o
);

    logic [LANES-1:0]          lane_wr;
    logic [NUM_REGS-1:0]       map_busy;
    logic [NUM_REGS*TAG_W-1:0] map_tag;

    assign lane_wr = ren_valid_i & ren_dst_we_i;

    rat_map_table #(
        .NUM_REGS (NUM_REGS),
        .LANES    (LANES),
        .TAG_W    (TAG_W),
        .NUM_CMP  (NUM_CMP)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (flush_i),
        .wr_valid_i  (lane_wr),
        .wr_dst_i    (ren_dst_i),
        .wr_tag_i    (ren_tag_i),
        .cmp_valid_i (cmp_valid_i),
        .cmp_tag_i   (cmp_tag_i),
        .busy_o      (map_busy),
        .tag_o       (map_tag)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rat_src_lookup #(
            .NUM_REGS (NUM_REGS),
            .LANES    (LANES),
            .TAG_W    (TAG_W),
            .NUM_CMP  (NUM_CMP),
            .LANE     (g)
        ) u_src_a (
            .clk         (clk),
            .rst_n       (rst_n),
            .src_i       (ren_src_a_i[g*AW +: AW]),
            .map_busy_i  (map_busy),
            .map_tag_i   (map_tag),
            .grp_wr_i    (lane_wr),
            .grp_dst_i   (ren_dst_i),
            .grp_tag_i   (ren_tag_i),
            .cmp_valid_i (cmp_valid_i),
            .cmp_tag_i   (cmp_tag_i),
            .busy_o      (src_a_busy_o[g]),
            .tag_o       (src_a_tag_o[g*TAG_W +: TAG_W])
        );

        rat_src_lookup #(
            .NUM_REGS (NUM_REGS),
            .LANES    (LANES),
            .TAG_W    (TAG_W),
            .NUM_CMP  (NUM_CMP),
            .LANE     (g)
        ) u_src_b (
            .clk         (clk),
            .rst_n       (rst_n),
            .src_i       (ren_src_b_i[g*AW +: AW]),
            .map_busy_i  (map_busy),
            .map_tag_i   (map_tag),
            .grp_wr_i    (lane_wr),
            .grp_dst_i   (ren_dst_i),
            .grp_tag_i   (ren_tag_i),
            .cmp_valid_i (cmp_valid_i),
            .cmp_tag_i   (cmp_tag_i),
            .busy_o      (src_b_busy_o[g]),
            .tag_o       (src_b_tag_o[g*TAG_W +: TAG_W])
        );
    end

endmodule

// File: tb/rename_alias_table_tb_top.sv
module rename_alias_table_tb_top;
    import rat_pkg::*;

    localparam int NR = RAT_NUM_REGS;
    localparam int L  = RAT_LANES;
    localparam int TW = RAT_TAG_W;
    localparam int NC = RAT_NUM_CMP;
    localparam int AW = $clog2(NR);

    logic            clk   = 1'b0;
    logic            rst_n = 1'b0;
    logic            flush = 1'b0;
    logic [L-1:0]    vld   = '0;
    logic [L-1:0]    we    = '0;
    logic [L*AW-1:0] dst   = '0;
    logic [L*AW-1:0] sa    = '0;
    logic [L*AW-1:0] sb    = '0;
    logic [L*TW-1:0] tg    = '0;
    logic [NC-1:0]   cv    = '0;
    logic [NC*TW-1:0] ct   = '0;
    logic [L-1:0]    a_busy, b_busy;
    logic [L*TW-1:0] a_tag, b_tag;

    always #2 clk = ~clk;

    rename_alias_table dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush),
        .ren_valid_i  (vld),
        .ren_dst_we_i (we),
        .ren_dst_i    (dst),
        .ren_tag_i    (tg),
        .ren_src_a_i  (sa),
        .ren_src_b_i  (sb),
        .cmp_valid_i  (cv),
        .cmp_tag_i    (ct),
        .src_a_busy_o (a_busy),
        .src_a_tag_o  (a_tag),
        .src_b_busy_o (b_busy),
        .src_b_tag_o  (b_tag)
    );

    typedef struct {
        string           req;
        int              lane;
        bit              side;
        bit              busy;
        logic [TW-1:0]   tag;
    } exp_t;

    exp_t          sbq[$];
    bit            m_busy[NR];
    logic [TW-1:0] m_tag[NR];
    int            n_chk  = 0;
    int            n_fail = 0;
    bit            done   = 1'b0;

    task automatic idle_group();
        vld = '0; we = '0; dst = '0; sa = '0; sb = '0; tg = '0;
        cv = '0; ct = '0; flush = 1'b0;
    endtask

    task automatic set_lane(int i, bit v, bit w, int d, int a, int b, logic [TW-1:0] t);
        vld[i] = v;
        we[i]  = w;
        dst[i*AW +: AW] = AW'(d);
        sa[i*AW +: AW]  = AW'(a);
        sb[i*AW +: AW]  = AW'(b);
        tg[i*TW +: TW]  = t;
    endtask

    task automatic set_cmp(int k, logic [TW-1:0] t);
        cv[k] = 1'b1;
        ct[k*TW +: TW] = t;
    endtask

    // Expected answer from the requirements: R11, R2, R9, R4/R5/R12, R1.
    function automatic void expect_src(string req, int lane, bit side, int s);
        bit            b;
        logic [TW-1:0] t;
        exp_t          e;
        b = 1'b0;
        t = '0;
        if (s != 0) begin
            b = m_busy[s];
            t = m_tag[s];
            for (int k = 0; k < NC; k++)
                if (b && cv[k] && ct[k*TW +: TW] == t) b = 1'b0;
            for (int j = 0; j < lane; j++)
                if (vld[j] && we[j] && int'(dst[j*AW +: AW]) == s) begin
                    b = 1'b1;
                    t = tg[j*TW +: TW];
                end
        end
        if (!b) t = '0;
        e.req = req; e.lane = lane; e.side = side; e.busy = b; e.tag = t;
        sbq.push_back(e);
    endfunction

    // Driver: push expectations for the current group, advance the model, wait.
    task automatic step(string req);
        bit            nb[NR];
        logic [TW-1:0] nt[NR];
        for (int i = 0; i < L; i++) begin
            expect_src(req, i, 1'b0, int'(sa[i*AW +: AW]));
            expect_src(req, i, 1'b1, int'(sb[i*AW +: AW]));
        end
        nb = m_busy;
        nt = m_tag;
        for (int r = 1; r < NR; r++) begin
            for (int k = 0; k < NC; k++)
                if (m_busy[r] && cv[k] && ct[k*TW +: TW] == m_tag[r]) begin
                    nb[r] = 1'b0;
                    nt[r] = '0;
                end
            for (int l = 0; l < L; l++)
                if (vld[l] && we[l] && int'(dst[l*AW +: AW]) == r) begin
                    nb[r] = 1'b1;
                    nt[r] = tg[l*TW +: TW];
                end
        end
        if (flush) begin
            for (int r = 0; r < NR; r++) begin
                nb[r] = 1'b0;
                nt[r] = '0;
            end
        end
        m_busy = nb;
        m_tag  = nt;
        @(negedge clk);
    endtask

    task automatic probe(string req, int r0, int r1, int r2, int r3, int r4, int r5, int r6, int r7);
        idle_group();
        set_lane(0, 1, 0, 0, r0, r1, '0);
        set_lane(1, 1, 0, 0, r2, r3, '0);
        set_lane(2, 1, 0, 0, r4, r5, '0);
        set_lane(3, 1, 0, 0, r6, r7, '0);
        step(req);
    endtask

    // Monitor: compare every queued expectation away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                exp_t          e;
                bit            ab;
                logic [TW-1:0] at;
                e  = sbq.pop_front();
                ab = e.side ? b_busy[e.lane] : a_busy[e.lane];
                at = e.side ? b_tag[e.lane*TW +: TW] : a_tag[e.lane*TW +: TW];
                n_chk++;
                if (ab !== e.busy || at !== e.tag) begin
                    n_fail++;
                    $display("FAIL %s lane %0d src_%s: actual busy=%0b tag=%h expected busy=%0b tag=%h",
                             e.req, e.lane, e.side ? "b" : "a", ab, at, e.busy, e.tag);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual still running, expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            m_busy[r] = 1'b0;
            m_tag[r]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: all registers ready after reset
        probe("R1", 1, 2, 3, 4, 5, 6, 7, 8);
        probe("R1", 25, 26, 27, 28, 29, 30, 31, 0);

        // R3: rename reg 5 with an adder tag; R2: probe it next cycle
        idle_group();
        set_lane(0, 1, 1, 5, 5, 0, make_tag(UNIT_ADD, 2'd1));
        set_lane(1, 1, 0, 0, 5, 5, '0);
        step("R3");
        probe("R2", 5, 4, 5, 6, 0, 5, 1, 5);

        // R4: in-group bypass with youngest older writer; R6 final entry
        idle_group();
        set_lane(0, 1, 1, 3, 3, 0, 4'h1);
        set_lane(1, 1, 1, 3, 3, 3, 4'h2);
        set_lane(2, 1, 0, 0, 3, 5, '0);
        set_lane(3, 1, 1, 3, 3, 3, 4'hc);
        step("R4");
        probe("R6", 3, 3, 3, 5, 3, 0, 3, 3);

        // R5: lane's own destination ignored for its sources
        idle_group();
        set_lane(0, 1, 1, 6, 6, 6, 4'h4);
        set_lane(2, 1, 1, 9, 9, 6, 4'h8);
        step("R5");
        probe("R5", 6, 9, 6, 9, 0, 0, 0, 0);

        // R7: stale completion keeps entry; matching one clears it
        idle_group();
        set_cmp(0, 4'h2);
        set_lane(0, 1, 0, 0, 3, 3, '0);
        step("R7");
        probe("R7", 3, 6, 3, 9, 5, 3, 0, 0);
        idle_group();
        set_cmp(1, 4'hc);
        set_lane(0, 1, 0, 0, 3, 6, '0);
        set_lane(1, 1, 1, 3, 0, 0, 4'hd);
        set_lane(2, 1, 0, 0, 3, 3, '0);
        step("R9");
        idle_group();
        set_cmp(0, 4'hd);
        set_cmp(1, 4'h4);
        set_lane(0, 1, 0, 0, 3, 6, '0);
        set_lane(3, 1, 0, 0, 9, 5, '0);
        step("R9");
        probe("R7", 3, 6, 9, 5, 3, 6, 0, 0);

        // R8: completion and re-rename with the same tag in one cycle
        idle_group();
        set_cmp(0, make_tag(UNIT_ADD, 2'd1));
        set_lane(0, 1, 1, 5, 5, 0, make_tag(UNIT_ADD, 2'd1));
        set_lane(1, 1, 0, 0, 5, 0, '0);
        step("R8");
        probe("R8", 5, 5, 0, 0, 0, 0, 5, 5);

        // R12: lanes without valid or without write enable
        idle_group();
        set_lane(0, 0, 1, 7, 0, 0, 4'h3);
        set_lane(1, 1, 0, 8, 0, 0, 4'h3);
        set_lane(2, 1, 0, 0, 7, 8, '0);
        set_lane(3, 1, 0, 0, 8, 7, '0);
        step("R12");
        probe("R12", 7, 8, 7, 8, 7, 8, 7, 8);

        // R11: register 0 as destination is ignored
        idle_group();
        set_lane(0, 1, 1, 0, 0, 0, 4'h5);
        set_lane(1, 1, 0, 0, 0, 0, '0);
        set_lane(2, 1, 1, 0, 0, 0, 4'h6);
        set_lane(3, 1, 0, 0, 0, 0, '0);
        step("R11");
        probe("R11", 0, 0, 0, 0, 0, 0, 0, 0);

        // R10: flush clears all entries and drops same-cycle renames
        idle_group();
        set_lane(0, 1, 1, 10, 0, 0, 4'ha);
        set_lane(1, 1, 1, 11, 10, 0, 4'hb);
        step("R10");
        idle_group();
        flush = 1'b1;
        set_lane(0, 1, 1, 12, 10, 11, 4'h7);
        set_lane(1, 1, 0, 0, 12, 5, '0);
        step("R10");
        probe("R10", 10, 11, 12, 5, 6, 9, 3, 13);

        // Mixed stress over a small register window: R2 R4 R6 R7 R9 R10
        for (int c = 0; c < 400; c++) begin
            idle_group();
            for (int i = 0; i < L; i++)
                set_lane(i, 1'($urandom % 2), 1'($urandom % 2), int'($urandom % 8),
                         int'($urandom % 8), int'($urandom % 8), TW'($urandom));
            for (int k = 0; k < NC; k++)
                if ($urandom % 2 == 1) set_cmp(k, TW'($urandom));
            flush = ($urandom % 50 == 0);
            step("R2");
        end
        probe("R10", 1, 2, 3, 4, 5, 6, 7, 0);

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule